// File: doc/BRIEF.md
# Two-Phase Pulse Generator with Pulse-Aligned Stop

The block drives one pulse-width-modulated output from a single down-counting phase timer. It alternates between an active phase that lasts `duty` clock cycles and an idle phase that lasts `period - duty` clock cycles. A polarity input picks the pin level of the active phase. Two settings are held as constant levels and do not toggle: a zero duty keeps the pin at the idle level, and a duty equal to a non-zero period keeps it at the active level.

A stop never cuts a pulse short. The request waits until the generator next enters its idle phase. At that entry the block pulses `stop_done` and drops `running`. A configuration request runs the same sequence in order. It stops the generator if it is running, loads the new settings in the cycle after the halt, and restarts when the request asks for a start or when the generator was running and no stop was requested. The block rejects a configuration whose duty would exceed its period. It compares the written fields against the held values of any fields that were not written.

Top module: `pwm_two_phase_gen`

## Requirements
- R1: After reset `running`, `cycle_end` and `stop_done` are 0. Polarity is active-high (1), period and duty are 0, and the pin is 0. Whenever `running` is 0 the pin is at the idle level, which is the inverse of the held polarity.
- R2: With 0 < duty < period, the pin stays active for exactly `duty` cycles and then idle for exactly `period - duty` cycles, repeating. The first phase after a start is the active phase, and it begins in the cycle after the start request is sampled.
- R3: With duty 0, the pin stays at the idle level and every phase counts as an idle entry, one per `period` cycles. With period 0 (and so duty 0), the idle entry occurs every cycle.
- R4: With duty equal to a non-zero period, the pin stays at the active level while running and `cycle_end` never pulses.
- R5: `cycle_end` is high in the first cycle of every idle phase, including the one entered by a start with duty 0. It is high for exactly one cycle per idle entry.
- R6: A plain `stop_req` while running is held until the next idle entry. In that first idle cycle `stop_done` and `cycle_end` are both 1 and `running` is 0. The last active phase keeps its full `duty` length.
- R7: With duty equal to period, a pending stop completes at the end of the current full-period phase.
- R8: `cfg_pol` = 1 makes the active level high, and `cfg_pol` = 0 makes it low.
- R9: A `start_req` while running has no effect. A `stop_req` while stopped has no effect.
- R10: A configuration is rejected and changes nothing when its resulting duty exceeds its resulting period. An unwritten field (`cfg_wr_period`/`cfg_wr_duty` = 0) keeps its held value for this comparison.
- R11: An accepted configuration while running acts as a stop. The new settings are loaded in the cycle after `stop_done`. The generator restarts in that same cycle unless `stop_req` was 1 with the request and `start_req` was 0.
- R12: An accepted configuration while stopped loads one cycle after it is sampled. It starts the generator only when `start_req` was 1 with it.
- R13: While a configuration is pending, further configuration, start and stop requests are ignored. When `cfg_req` is 1, `start_req`/`stop_req` act only as flags of that configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer counts its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Start request, or restart flag together with `cfg_req` |
| stop_req | input | 1 | Stop request, or no-restart flag together with `cfg_req` |
| cfg_req | input | 1 | Configuration request, one cycle |
| cfg_wr_period | input | 1 | Write `cfg_period` with this request |
| cfg_wr_duty | input | 1 | Write `cfg_duty` with this request |
| cfg_period | input | 16 | New period in clock cycles |
| cfg_duty | input | 16 | New active length in clock cycles |
| cfg_pol | input | 1 | New polarity, 1 = active high (always loaded) |
| pwm_out | output | 1 | Pulse output |
| cycle_end | output | 1 | Pulse on each idle-phase entry |
| stop_done | output | 1 | Pulse when a stop completes |
| running | output | 1 | Generator active |

## Verification
A wrong phase bit or a wrong timer value shows at `pwm_out` no later than the next phase boundary, and it shifts every later `cycle_end` pulse. A lost or sticky stop request shows up within one period, either as a missing `stop_done` or as an early halt that truncates the active run. A wrong pending-configuration state appears one cycle after the halt as a missing restart or as the wrong pulse width. The bench's reference model compares all four outputs on every cycle, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/pwm2p_pkg.sv
// Shared types for the two-phase pulse generator.
// Assumes: phase state is one bit, active or idle.
package pwm2p_pkg;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;

    // Phase that follows a timer expiry when no stop is pending.
    function automatic phase_e phase_after(phase_e cur, logic zero_duty, logic full_duty);
        if (zero_duty)      return PH_IDLE;
        else if (full_duty) return PH_ACTIVE;
        else                return (cur == PH_ACTIVE) ? PH_IDLE : PH_ACTIVE;
    endfunction

endpackage

// File: rtl/pwm2p_phase_timer.sv
// Down-counting phase timer.
// Loads a phase length and raises expire in the last cycle of that phase.
// Assumes: a length of zero is treated as one cycle; counting only while run is high.
module pwm2p_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         run,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    // Holds the remaining cycles of the current phase, minus one.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= (len == '0) ? '0 : len - W'(1);
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
    end

    assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/pwm2p_cfg_stage.sv
// Configuration staging: validates a request against the held settings,
// holds it pending until the generator is halted, then commits it.
// Assumes: apply is only raised while a request is pending and the generator is stopped.
module pwm2p_cfg_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_req,
    input  logic         cfg_wr_period,
    input  logic         cfg_wr_duty,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_duty,
    input  logic         cfg_pol,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic         running,
    input  logic         apply,
    output logic         accept,
    output logic         pend,
    output logic         restart,
    output logic [W-1:0] period_q,
    output logic [W-1:0] duty_q,
    output logic         pol_q,
    output logic [W-1:0] eff_period,
    output logic [W-1:0] eff_duty
);
    logic [W-1:0] new_period, new_duty;
    logic [W-1:0] stg_period, stg_duty;
    logic         stg_pol;

    // Resolve the settings the request would produce and check them.
    always_comb begin
        new_period = cfg_wr_period ? cfg_period : period_q;
        new_duty   = cfg_wr_duty   ? cfg_duty   : duty_q;
        accept     = cfg_req && !pend && (new_duty <= new_period);
    end

    // Capture an accepted request and its restart decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend       <= 1'b0;
            restart    <= 1'b0;
            stg_period <= '0;
            stg_duty   <= '0;
            stg_pol    <= 1'b1;
        end else if (accept) begin
            pend       <= 1'b1;
            restart    <= start_req || (running && !stop_req);
            stg_period <= new_period;
            stg_duty   <= new_duty;
            stg_pol    <= cfg_pol;
        end else if (apply) begin
            pend       <= 1'b0;
        end
    end

    // Commit the staged settings to the live registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            duty_q   <= '0;
            pol_q    <= 1'b1;
        end else if (apply) begin
            period_q <= stg_period;
            duty_q   <= stg_duty;
            pol_q    <= stg_pol;
        end
    end

    // Settings seen by the sequencer this cycle, including one being committed.
    assign eff_period = apply ? stg_period : period_q;
    assign eff_duty   = apply ? stg_duty   : duty_q;
endmodule

// File: rtl/pwm2p_sequencer.sv
// Phase sequencer: starts the generator, advances the phase on timer expiry,
// and honours a pending stop only when the idle phase is entered.
// Assumes: stop_q is only ever set while running.
module pwm2p_sequencer
    import pwm2p_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic         cfg_req,
    input  logic         accept,
    input  logic         pend,
    input  logic         restart,
    input  logic [W-1:0] eff_period,
    input  logic [W-1:0] eff_duty,
    input  logic         expire,
    output logic         apply,
    output logic         load,
    output logic [W-1:0] load_len,
    output logic         run_q,
    output phase_e       act_q,
    output logic         eoc_q,
    output logic         done_q
);
    logic   stop_q;
    logic   run_n, stop_n, eoc_n, done_n;
    phase_e act_n, nxt;
    logic   zero_duty, full_duty, do_start, plain_start;

    assign zero_duty   = (eff_duty == '0);
    assign full_duty   = (eff_duty == eff_period) && !zero_duty;
    assign apply       = pend && !run_q;
    assign plain_start = !run_q && !pend && start_req && !cfg_req;
    assign do_start    = plain_start || (apply && restart);

    // Next phase, stop completion and timer load for this cycle.
    always_comb begin
        run_n    = run_q;
        act_n    = act_q;
        stop_n   = stop_q;
        eoc_n    = 1'b0;
        done_n   = 1'b0;
        load     = 1'b0;
        nxt      = act_q;
        if (do_start) begin
            nxt = zero_duty ? PH_IDLE : PH_ACTIVE;
        end else if (expire) begin
            nxt = phase_after(act_q, zero_duty, full_duty);
            if (full_duty && stop_q) nxt = PH_IDLE;
        end
        if (do_start) run_n = 1'b1;
        if (do_start || expire) begin
            act_n = nxt;
            if (nxt == PH_IDLE) begin
                eoc_n = 1'b1;
                if (stop_q && !do_start) begin
                    done_n = 1'b1;
                    run_n  = 1'b0;
                    stop_n = 1'b0;
                end else begin
                    load = 1'b1;
                end
            end else begin
                load = 1'b1;
            end
        end
        if (do_start) stop_n = 1'b0;
        if (run_q && run_n && ((stop_req && !cfg_req && !pend) || accept))
            stop_n = 1'b1;
        load_len = (nxt == PH_ACTIVE) ? eff_duty : eff_period - eff_duty;
    end

    // Phase, run, stop and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            act_q  <= PH_IDLE;
            stop_q <= 1'b0;
            eoc_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            run_q  <= run_n;
            act_q  <= act_n;
            stop_q <= stop_n;
            eoc_q  <= eoc_n;
            done_q <= done_n;
        end
    end
endmodule

// File: rtl/pwm_two_phase_gen.sv
// Two-phase pulse generator top: configuration staging, sequencer and phase timer.
// Assumes: all inputs synchronous to clk; widths set by W.
module pwm_two_phase_gen
    import pwm2p_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_req,
    input  logic         stop_req,
    input  logic         cfg_req,
    input  logic         cfg_wr_period,
    input  logic         cfg_wr_duty,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_duty,
    input  logic         cfg_pol,
    output logic         pwm_out,
    output logic         cycle_end,
    output logic         stop_done,
    output logic         running
);
    logic         accept, pend, restart, apply, load, expire;
    logic [W-1:0] period_q, duty_q, eff_period, eff_duty, load_len;
    logic         pol_q;
    phase_e       act;

    pwm2p_cfg_stage #(.W(W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req),
        .cfg_wr_period(cfg_wr_period), .cfg_wr_duty(cfg_wr_duty),
        .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_pol(cfg_pol),
        .start_req(start_req), .stop_req(stop_req), .running(running),
        .apply(apply), .accept(accept), .pend(pend), .restart(restart),
        .period_q(period_q), .duty_q(duty_q), .pol_q(pol_q),
        .eff_period(eff_period), .eff_duty(eff_duty)
    );

    pwm2p_sequencer #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .cfg_req(cfg_req), .accept(accept), .pend(pend), .restart(restart),
        .eff_period(eff_period), .eff_duty(eff_duty), .expire(expire),
        .apply(apply), .load(load), .load_len(load_len), .run_q(running),
        .act_q(act), .eoc_q(cycle_end), .done_q(stop_done)
    );

    pwm2p_phase_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(load), .len(load_len),
        .run(running), .expire(expire)
    );

    // Active phase drives the polarity level, idle phase its inverse.
    assign pwm_out = (act == PH_ACTIVE) ? pol_q : ~pol_q;
endmodule

// File: rtl/pwm2p_checker.sv
// Property checker for the two-phase pulse generator, bound to the top.
module pwm2p_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pwm_out,
    input logic         cycle_end,
    input logic         stop_done,
    input logic         running,
    input logic         pol,
    input logic [W-1:0] duty,
    input logic [W-1:0] period
);
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == !pol));

    p_zero_duty_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty == '0) |-> (pwm_out == !pol));

    p_full_duty_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && duty == period && duty != '0) |-> (pwm_out == pol));

    p_end_is_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |-> (pwm_out == !pol));

    p_done_drops_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> (!running && cycle_end));

    p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_done |-> $past(running));
endmodule

bind pwm_two_phase_gen pwm2p_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .cycle_end(cycle_end),
    .stop_done(stop_done), .running(running), .pol(pol_q),
    .duty(duty_q), .period(period_q)
);

// File: tb/pwm_two_phase_gen_bench.sv
module pwm_two_phase_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0, stop_req = 1'b0, cfg_req = 1'b0;
    logic        cfg_wr_period = 1'b0, cfg_wr_duty = 1'b0, cfg_pol = 1'b1;
    logic [15:0] cfg_period = '0, cfg_duty = '0;
    logic        pwm_out, cycle_end, stop_done, running;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    pwm_two_phase_gen u_pwm_two_phase_gen (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .cfg_req(cfg_req), .cfg_wr_period(cfg_wr_period), .cfg_wr_duty(cfg_wr_duty),
        .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_pol(cfg_pol),
        .pwm_out(pwm_out), .cycle_end(cycle_end), .stop_done(stop_done),
        .running(running)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model, updated at each rising edge.
    int m_per, m_dut, s_per, s_dut, m_rem;
    bit m_pol, s_pol, s_rst, m_run, m_act, m_stop, m_pend, m_eoc, m_done;

    task automatic m_enter(bit a);
        int len;
        m_act = a;
        if (!a) begin
            m_eoc = 1;
            if (m_stop) begin
                m_done = 1; m_run = 0; m_stop = 0;
                return;
            end
        end
        len = a ? m_dut : m_per - m_dut;
        m_rem = (len == 0) ? 1 : len;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_per = 0; m_dut = 0; m_pol = 1; s_per = 0; s_dut = 0; s_pol = 1; s_rst = 0;
            m_run = 0; m_act = 0; m_stop = 0; m_pend = 0; m_eoc = 0; m_done = 0; m_rem = 1;
        end else begin
            bit o_run, o_pend, o_apply, acc, go;
            int np, nd;
            o_run = m_run; o_pend = m_pend; o_apply = m_pend && !m_run;
            np = cfg_wr_period ? int'(cfg_period) : m_per;
            nd = cfg_wr_duty ? int'(cfg_duty) : m_dut;
            acc = cfg_req && !o_pend && (nd <= np);
            go = (!o_run && !o_pend && start_req && !cfg_req) || (o_apply && s_rst);
            m_eoc = 0; m_done = 0;
            if (o_apply) begin
                m_per = s_per; m_dut = s_dut; m_pol = s_pol; m_pend = 0;
            end
            if (acc) begin
                s_per = np; s_dut = nd; s_pol = cfg_pol; m_pend = 1;
                s_rst = start_req || (o_run && !stop_req);
            end
            if (go) begin
                m_stop = 0; m_run = 1;
                m_enter(m_dut != 0);
            end else if (o_run && m_rem == 1) begin
                if (m_dut == 0) m_enter(0);
                else if (m_dut == m_per) m_enter(!m_stop);
                else m_enter(!m_act);
            end else if (o_run) begin
                m_rem--;
            end
            if (o_run && m_run && ((stop_req && !cfg_req && !o_pend) || acc)) m_stop = 1;
        end
    end

    // Per-cycle comparison and observation counters, away from the rising edge.
    int hi_cnt = 0, lo_cnt = 0, eoc_cnt = 0, done_cnt = 0, cur_hi = 0, last_hi = 0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit m_pin;
            m_pin = m_act ? m_pol : !m_pol;
            nchk++;
            if (pwm_out !== m_pin) begin
                nerr++; $display("FAIL R2 pin actual=%0b expected=%0b t=%0t", pwm_out, m_pin, $time);
            end else if (cycle_end !== m_eoc) begin
                nerr++; $display("FAIL R5 cycle_end actual=%0b expected=%0b t=%0t", cycle_end, m_eoc, $time);
            end else if (stop_done !== m_done) begin
                nerr++; $display("FAIL R6 stop_done actual=%0b expected=%0b t=%0t", stop_done, m_done, $time);
            end else if (running !== m_run) begin
                nerr++; $display("FAIL R11 running actual=%0b expected=%0b t=%0t", running, m_run, $time);
            end
            if (pwm_out) begin hi_cnt++; cur_hi++; end
            else begin
                lo_cnt++;
                if (cur_hi > 0) last_hi = cur_hi;
                cur_hi = 0;
            end
            if (cycle_end) eoc_cnt++;
            if (stop_done) done_cnt++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_cfg(int p, int d, bit wp, bit wd, bit pol, bit st, bit sp);
        cfg_req = 1; cfg_period = 16'(p); cfg_duty = 16'(d);
        cfg_wr_period = wp; cfg_wr_duty = wd; cfg_pol = pol; start_req = st; stop_req = sp;
        cyc(1);
        cfg_req = 0; cfg_wr_period = 0; cfg_wr_duty = 0; start_req = 0; stop_req = 0;
    endtask

    task automatic do_start();
        start_req = 1; cyc(1); start_req = 0;
    endtask

    task automatic do_stop();
        stop_req = 1; cyc(1); stop_req = 0;
    endtask

    task automatic wait_done(string tag, int maxc);
        int base = done_cnt;
        for (int i = 0; i < maxc && done_cnt == base; i++) cyc(1);
        chk(tag, done_cnt - base, 1);
    endtask

    task automatic window(int n, output int dh, output int dl, output int de);
        int h0 = hi_cnt, l0 = lo_cnt, e0 = eoc_cnt;
        cyc(n);
        dh = hi_cnt - h0; dl = lo_cnt - l0; de = eoc_cnt - e0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int dh, dl, de, d0;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        chk("R1 running", running, 0);
        chk("R1 pin", pwm_out, 0);
        chk("R1 cycle_end", cycle_end, 0);

        // R12 + R2 + R5: configure while stopped with start flag
        do_cfg(10, 3, 1, 1, 1, 1, 0);
        cyc(3);
        chk("R12 running after cfg start", running, 1);
        window(30, dh, dl, de);
        chk("R2 active cycles", dh, 9);
        chk("R5 cycle_end count", de, 3);

        // R9 start while running ignored
        do_start();
        window(30, dh, dl, de);
        chk("R9 active cycles after extra start", dh, 9);

        // R6 graceful stop
        do_stop();
        wait_done("R6 stop_done seen", 40);
        chk("R6 last pulse untruncated", last_hi, 3);
        chk("R6 running low", running, 0);
        d0 = done_cnt;
        do_stop();
        window(30, dh, dl, de);
        chk("R9 stop while idle", done_cnt - d0, 0);
        chk("R1 idle pin", pwm_out, 0);

        // R12 cfg without start, then R3 duty zero
        do_cfg(8, 0, 1, 1, 1, 0, 0);
        cyc(5);
        chk("R12 no start without flag", running, 0);
        do_start();
        window(24, dh, dl, de);
        chk("R3 zero duty active cycles", dh, 0);
        chk("R3 zero duty idle entries", de, 3);
        do_stop();
        wait_done("R6 stop with zero duty", 12);

        // R3 period zero
        do_cfg(0, 0, 1, 1, 1, 1, 0);
        cyc(3);
        window(10, dh, dl, de);
        chk("R3 period zero idle entries", de, 10);
        chk("R3 period zero active", dh, 0);
        do_stop();
        wait_done("R6 stop period zero", 4);

        // R4 full duty, R7 stop in full duty
        do_cfg(6, 6, 1, 1, 1, 1, 0);
        cyc(3);
        window(18, dh, dl, de);
        chk("R4 full duty active", dh, 18);
        chk("R4 full duty no cycle_end", de, 0);
        do_stop();
        wait_done("R7 stop in full duty", 8);
        chk("R7 pin idle after stop", pwm_out, 0);

        // R8 low polarity
        do_cfg(10, 4, 1, 1, 0, 1, 0);
        cyc(3);
        window(30, dh, dl, de);
        chk("R8 low-active cycles", dl, 12);

        // R10 rejected configurations
        d0 = done_cnt;
        do_cfg(0, 12, 0, 1, 0, 0, 0);
        window(30, dh, dl, de);
        chk("R10 duty>period rejected", dl, 12);
        do_cfg(3, 0, 1, 0, 0, 0, 0);
        window(30, dh, dl, de);
        chk("R10 period<held duty rejected", dl, 12);
        chk("R10 no stop", done_cnt - d0, 0);
        chk("R10 still running", running, 1);

        // R11 cfg while running restarts
        do_cfg(12, 5, 1, 1, 0, 0, 0);
        wait_done("R11 cfg stops first", 30);
        cyc(3);
        chk("R11 restarted", running, 1);
        window(36, dh, dl, de);
        chk("R11 new duty", dl, 15);

        // R11 cfg with stop flag stays stopped, then applied values used
        do_cfg(12, 2, 1, 1, 0, 0, 1);
        wait_done("R11 cfg with stop flag", 30);
        cyc(20);
        chk("R11 stays stopped", running, 0);
        do_start();
        cyc(2);
        window(36, dh, dl, de);
        chk("R11 applied duty", dl, 6);

        // R13 second cfg while pending is ignored
        do_cfg(20, 10, 1, 1, 0, 0, 0);
        do_cfg(4, 1, 1, 1, 0, 0, 0);
        wait_done("R13 pending stop", 30);
        cyc(4);
        window(60, dh, dl, de);
        chk("R13 first cfg kept", dl, 30);
        do_stop();
        wait_done("R6 final stop", 30);

        cyc(5);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule